// File: doc/BRIEF.md
# Two-Modulus Swallow-Counter Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It takes a fast input clock and emits one short pulse for every N input clocks. That pulse goes to the phase detector. The block does not use one wide divide-by-N counter. A small prescaler runs at the full input rate and divides by either P or P+1. Two slower counters count the prescaler's output cycles and choose the modulus. The swallow count sets how many prescaler cycles use P+1. The main count sets the length of the whole period. The resulting ratio is N = P·B + A.

Each period opens with A prescaler cycles at divide-by-(P+1), with the modulus-select output held high. The remaining B−A prescaler cycles run at divide-by-P, with modulus-select low. Both counters reload together when the main count reaches its terminal value.

New settings are written through a load strobe. They are checked on arrival, held in a pending stage, and applied only at a period boundary, so a reload never corrupts a running period. An illegal setting is discarded and flagged.

Top module: `pswallow_div`

## Requirements
- R1: The spacing from one rising edge of `div_pulse` to the next equals P·B + A input clocks for the active setting. After reset the active setting is P=8, A=2, B=11, which gives 90.
- R2: `div_pulse` is high for exactly one input clock per period.
- R3: Within each period, counted from the clock in which `div_pulse` is high, `mod_hi` is high for the first A·(P+1) input clocks and low for the remaining P·(B−A) clocks. `mod_hi` rises only at a period boundary and falls only at the end of a prescaler cycle.
- R4: With A = 0, `mod_hi` stays low for the whole period, and the ratio is P·B.
- R5: A = B is legal. The whole period then runs at P+1, `mod_hi` stays high for all N clocks, and N = (P+1)·B.
- R6: A load with B = 0, with A > B, or with P < 2 is rejected. `cfg_err` goes high for one clock, in the cycle after the strobe, and the previously active ratio continues unchanged.
- R7: An accepted load that arrives while a period is running does not change that period. The period that starts at the next boundary uses the new P, A and B.
- R8: While reset is held, `div_pulse` and `cfg_err` are low, and `mod_hi` is high because the default A is nonzero.
- R9: The smallest legal ratio, P=2, A=0, B=1, gives a pulse every 2 input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (the oscillator being divided) |
| rst | input | 1 | Synchronous reset, active high |
| cfg_p | input | P_W | Prescaler base modulus P |
| cfg_a | input | CNT_W | Swallow count A |
| cfg_b | input | CNT_W | Main count B |
| cfg_load | input | 1 | Strobe that presents cfg_p, cfg_a and cfg_b |
| cfg_err | output | 1 | One-clock flag for a rejected load |
| mod_hi | output | 1 | Modulus select: 1 = divide by P+1, 0 = divide by P |
| div_pulse | output | 1 | One-clock divided output pulse |

## Verification
The bench measures the pulse spacing and the number of clocks with `mod_hi` high under several settings. These include A = 0, A = B−1, A = B and the minimum ratio. A design that swapped the order of the moduli, or counted A past the terminal value, would show a wrong modulus-high count even when its period looks right. A design that was off by one in the prescaler limit would shift N by B.

A load is issued in the middle of a period to check that the current period still has the old length. A design that reloaded at once would produce a hybrid interval instead. Illegal loads are checked for the error flag, and the bench then confirms the old ratio still holds. A design that accepted B = 0 would stall or wrap its counter.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // A setting is usable when the prescaler divides by at least 2,
  // at least one prescaler cycle exists, and the swallow count fits in it.
  function automatic logic cfg_ok(input int p, input int a, input int b);
    return (p >= 2) && (b >= 1) && (a <= b);
  endfunction

  // Input clocks per output period.
  function automatic int total_ratio(input int p, input int a, input int b);
    return p * b + a;
  endfunction

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int P_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] p_val,
  input  logic           mod_sel,
  output logic           tick
);
  localparam int CW = P_W + 1;
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  // The last count of a cycle is P (for P+1 clocks) or P-1 (for P clocks).
  always_comb begin
    limit = mod_sel ? {1'b0, p_val} : ({1'b0, p_val} - ONE);
  end

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + ONE;
  end
endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters #(
  parameter int CNT_W = 8,
  parameter int A_DEF = 2,
  parameter int B_DEF = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] ld_a,
  input  logic [CNT_W-1:0] ld_b,
  output logic             mod_hi,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] a_cnt;
  logic [CNT_W-1:0] b_cnt;
  logic             last;

  assign mod_hi = (a_cnt != '0);
  assign last   = (b_cnt == ONE);
  assign wrap   = tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= A_DEF[CNT_W-1:0];
      b_cnt <= B_DEF[CNT_W-1:0];
    end else if (tick) begin
      if (last) begin
        a_cnt <= ld_a;
        b_cnt <= ld_b;
      end else begin
        b_cnt <= b_cnt - ONE;
        if (a_cnt != '0) a_cnt <= a_cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/pswallow_cfg.sv
module pswallow_cfg #(
  parameter int P_W   = 5,
  parameter int CNT_W = 8,
  parameter int P_DEF = 8,
  parameter int A_DEF = 2,
  parameter int B_DEF = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [P_W-1:0]   in_p,
  input  logic [CNT_W-1:0] in_a,
  input  logic [CNT_W-1:0] in_b,
  input  logic             in_load,
  input  logic             wrap,
  output logic [P_W-1:0]   act_p,
  output logic [CNT_W-1:0] nxt_a,
  output logic [CNT_W-1:0] nxt_b,
  output logic             rej
);
  import pswallow_pkg::*;

  logic [P_W-1:0]   pend_p;
  logic [CNT_W-1:0] pend_a, pend_b, act_a, act_b;
  logic             pend_v;
  logic             good;

  assign good  = cfg_ok(int'(in_p), int'(in_a), int'(in_b));
  assign nxt_a = pend_v ? pend_a : act_a;
  assign nxt_b = pend_v ? pend_b : act_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_p  <= P_DEF[P_W-1:0];
      act_a  <= A_DEF[CNT_W-1:0];
      act_b  <= B_DEF[CNT_W-1:0];
      pend_p <= '0;
      pend_a <= '0;
      pend_b <= '0;
      pend_v <= 1'b0;
      rej    <= 1'b0;
    end else begin
      rej <= in_load && !good;
      if (wrap) begin
        if (pend_v) begin
          act_p <= pend_p;
          act_a <= pend_a;
          act_b <= pend_b;
        end
        pend_v <= 1'b0;
      end
      // A load in the boundary cycle waits for the following boundary.
      if (in_load && good) begin
        pend_p <= in_p;
        pend_a <= in_a;
        pend_b <= in_b;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int P_W   = 5,
  parameter int CNT_W = 8,
  parameter int P_DEF = 8,
  parameter int A_DEF = 2,
  parameter int B_DEF = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [P_W-1:0]   cfg_p,
  input  logic [CNT_W-1:0] cfg_a,
  input  logic [CNT_W-1:0] cfg_b,
  input  logic             cfg_load,
  output logic             cfg_err,
  output logic             mod_hi,
  output logic             div_pulse
);
  // Internal events, named for the checker.
  logic             pre_tick;
  logic             period_wrap;
  logic [P_W-1:0]   act_p;
  logic [CNT_W-1:0] nxt_a, nxt_b;

  pswallow_cfg #(.P_W(P_W), .CNT_W(CNT_W), .P_DEF(P_DEF), .A_DEF(A_DEF), .B_DEF(B_DEF)) cfg_i (
    .clk(clk), .rst(rst), .in_p(cfg_p), .in_a(cfg_a), .in_b(cfg_b), .in_load(cfg_load),
    .wrap(period_wrap), .act_p(act_p), .nxt_a(nxt_a), .nxt_b(nxt_b), .rej(cfg_err)
  );

  pswallow_prescaler #(.P_W(P_W)) pre_i (
    .clk(clk), .rst(rst), .p_val(act_p), .mod_sel(mod_hi), .tick(pre_tick)
  );

  pswallow_counters #(.CNT_W(CNT_W), .A_DEF(A_DEF), .B_DEF(B_DEF)) cnt_i (
    .clk(clk), .rst(rst), .tick(pre_tick), .ld_a(nxt_a), .ld_b(nxt_b),
    .mod_hi(mod_hi), .wrap(period_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= period_wrap;
  end
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int P_W   = 5,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [P_W-1:0]   cfg_p,
  input logic [CNT_W-1:0] cfg_a,
  input logic [CNT_W-1:0] cfg_b,
  input logic             cfg_load,
  input logic             cfg_err,
  input logic             mod_hi,
  input logic             div_pulse,
  input logic             pre_tick,
  input logic             period_wrap,
  input logic [P_W-1:0]   act_p
);
  logic bad_load;
  assign bad_load = cfg_load && ((cfg_b == '0) || (cfg_a > cfg_b) || (cfg_p < 2));

  p_pulse_at_boundary_r1: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(period_wrap));

  p_pulse_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  p_mod_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_hi) |-> $past(period_wrap));

  p_mod_fall_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_hi) |-> $past(pre_tick));

  p_reject_flag_r6: assert property (@(posedge clk) disable iff (rst)
    bad_load |=> cfg_err);

  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_p) |-> $past(period_wrap));
endmodule

bind pswallow_div pswallow_div_chk #(.P_W(P_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_p(cfg_p), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_load(cfg_load),
  .cfg_err(cfg_err), .mod_hi(mod_hi), .div_pulse(div_pulse), .pre_tick(pre_tick),
  .period_wrap(period_wrap), .act_p(act_p)
);

// File: tb/pswallow_div_tb_top.sv
module pswallow_div_tb_top;
  localparam int P_W = 5;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P_W-1:0] cfg_p = '0;
  logic [CNT_W-1:0] cfg_a = '0, cfg_b = '0;
  logic cfg_load = 1'b0;
  logic cfg_err, mod_hi, div_pulse;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  pswallow_div #(.P_W(P_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_p(cfg_p), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_load(cfg_load),
    .cfg_err(cfg_err), .mod_hi(mod_hi), .div_pulse(div_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  // Waits at falling edges until a pulse is seen.
  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // Called in a pulse cycle: counts clocks and mod_hi-high clocks up to the next pulse.
  task automatic run_period(output int n, output int hi, output int wide);
    n = 0; hi = 0; wide = 0;
    do begin
      n++;
      if (mod_hi) hi++;
      @(negedge clk);
      if (n == 1 && div_pulse) wide = 1;
    end while (!div_pulse);
  endtask

  task automatic do_load(input int p, input int a, input int b, output int err);
    @(negedge clk);
    cfg_p = P_W'(p); cfg_a = CNT_W'(a); cfg_b = CNT_W'(b); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    err = int'(cfg_err);
  endtask

  // Loads a legal setting, skips the transition, then checks one clean period.
  task automatic t_ratio(input string req, input int p, input int a, input int b);
    int n, hi, wide, err;
    do_load(p, a, b, err);
    check({req, " accepted load no flag"}, err, 0);
    wait_pulse(); run_period(n, hi, wide);
    run_period(n, hi, wide);
    run_period(n, hi, wide);
    check({req, " R1 period"}, n, p * b + a);
    check({req, " R3 mod_hi clocks"}, hi, a * (p + 1));
    check({req, " R2 pulse width"}, wide, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 div_pulse in reset", int'(div_pulse), 0);
    check("R8 cfg_err in reset", int'(cfg_err), 0);
    check("R8 mod_hi in reset", int'(mod_hi), 1);
    rst = 1'b0;
  endtask

  task automatic t_default();
    int n, hi, wide;
    wait_pulse(); run_period(n, hi, wide);
    check("R1 default period 90", n, 90);
    check("R3 default mod_hi clocks", hi, 18);
    check("R2 default pulse width", wide, 0);
  endtask

  task automatic t_reject(input string why, input int p, input int a, input int b, input int keep_n);
    int n, hi, wide, err;
    do_load(p, a, b, err);
    check({"R6 flag ", why}, err, 1);
    @(negedge clk);
    check({"R6 flag one clock ", why}, int'(cfg_err), 0);
    wait_pulse(); run_period(n, hi, wide);
    run_period(n, hi, wide);
    check({"R6 old ratio kept ", why}, n, keep_n);
  endtask

  task automatic t_midload();
    int n, hi, wide;
    wait_pulse();
    // Present the load in the pulse cycle, i.e. just after a boundary.
    cfg_p = 5'd6; cfg_a = 8'd5; cfg_b = 8'd7; cfg_load = 1'b1;
    run_period(n, hi, wide);
    cfg_load = 1'b0;
    check("R7 running period keeps old ratio", n, 23);
    run_period(n, hi, wide);
    check("R7 next period uses new ratio", n, 47);
    check("R7 next period mod_hi clocks", hi, 35);
  endtask

  initial begin
    t_reset();
    t_default();
    t_ratio("R4 A=0 N=72", 8, 0, 9);
    t_ratio("R4 A=0 N=56", 8, 0, 7);
    t_ratio("R3 A=B-1", 5, 3, 4);
    t_ratio("R5 A=B", 4, 3, 3);
    t_ratio("R9 minimum", 2, 0, 1);
    t_ratio("R1 P=8 A=2 B=11", 8, 2, 11);
    t_ratio("R3 A=B-1 second", 5, 3, 4);
    t_reject("B=0", 7, 0, 0, 23);
    t_reject("A>B", 7, 5, 4, 23);
    t_reject("P<2", 1, 0, 3, 23);
    t_midload();
    finish_run();
  end
endmodule